// File: doc/BRIEF.md
# Time-Slot Switch Host Access Port

This block is the host side of a time-slot switch. A processor reaches the switch through one request channel, much like a small synchronous RAM. A 12-bit address and 16-bit write data go in. Read data comes back on a response channel one cycle after the read is accepted. The top two address bits pick a region:

- the switch's data memory, which the host can only read;
- the connection memory, which is stored inside this block;
- a small register file: a control register, a read-only frame alignment value and a set of frame offset registers.

Address bits 11:10 with value 2'b00 select no region.

The control register carries the fields listed in R5. When the host writes the control register with both the fill-mode bit and the go bit set, a sequencer copies the fill data into every connection-memory entry, one entry per clock. While the fill runs, the block refuses host writes to the connection memory through back-pressure. The block also works out the chip-wide output enable from an external enable pin and the standby bit. A second read port on the connection memory feeds the switching datapath.

The request channel uses valid/ready. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The host must hold its request steady while `req_ready` is low. `req_ready` is low only for a connection-memory write during a fill. The response channel has no ready: `rsp_valid` lasts one cycle and the host must take the data then.

Top module: `tsi_host_port`

## Requirements
- R1: Address bits [11:10] decode as follows, with bits [9:0] as the location inside the region:
  - 2'b11: data memory;
  - 2'b10: connection memory;
  - 2'b01: registers;
  - 2'b00: unmapped.
- R2: Every accepted read raises `rsp_valid` for exactly one cycle, in the cycle after acceptance, with the read data on `rsp_rdata`. Accepted writes produce no response.
- R3: A connection-memory entry written by the host reads back with the written 16-bit value.
- R4: A data-memory read drives `dm_re` high with `dm_addr` = A[9:0]. `dm_rdata`, which the data memory returns one cycle later, becomes the response. Host writes to the data-memory region never raise `dm_re` and change no state.
- R5: The control register sits at register offset 0. Its bit layout:
  - [0]: standby;
  - [1]: start-frame-evaluation;
  - [3:2]: rate select;
  - [4]: fill mode;
  - [5]: go;
  - [8:6]: fill data;
  - [9]: read-only done flag;
  - [15:10]: read zero.
  Bit 1 appears on `sfe_out`, and bits [3:2] appear on `rate_sel`.
- R6: The frame offset registers sit at register offsets 2 to 5. They are 16 bits each, read/write, and are driven on `fo_regs`, with register k at bits [16k+15:16k].
- R7: Register offset 1 returns `fa_value`, and writes to it are ignored. Reads of other register offsets, and of region 2'b00, return zero.
- R8: A control write with go and fill mode both 1 starts a fill. A control write with go = 1 but fill mode = 0 starts nothing and leaves go reading 0.
- R9: A fill writes {fill data, 13'b0} into every connection-memory entry, one per clock, in 1024 cycles. At the end it clears go and sets done. Starting a new fill clears done.
- R10: While a fill runs, `req_ready` is low for connection-memory writes and high for every other request. A held write completes after the fill and overrides the fill value.
- R11: `oe_all` is high when `ode_pin` is high. When `ode_pin` is low, `oe_all` follows the standby bit.
- R12: `sw_cm_rdata` returns the connection-memory entry at `sw_cm_addr` one cycle after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Host address |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 16 | Read data |
| dm_re | output | 1 | Data-memory read strobe |
| dm_addr | output | 10 | Data-memory location |
| dm_rdata | input | 16 | Data-memory word, one cycle after dm_re |
| sw_cm_addr | input | 10 | Datapath connection-memory read address |
| sw_cm_rdata | output | 16 | Datapath connection-memory read data |
| fa_value | input | 16 | Frame alignment value from timing logic |
| fo_regs | output | 64 | Frame offset registers, concatenated |
| sfe_out | output | 1 | Start-frame-evaluation control bit |
| rate_sel | output | 2 | Data-rate select field |
| ode_pin | input | 1 | External output-enable pin |
| oe_all | output | 1 | Global output enable |

## Verification
Reads are issued to all four regions so that a wrong region decode shows up as data from the wrong source. Unmapped register offsets and the read-only alignment location are included. Writes go to the data-memory region and to the read-only bits, and the bench then watches the strobe and reads back the contents those writes might have corrupted. The fill is run once with fill mode clear and once with it set. The second run checks the first, middle and last entries, and it sends a connection-memory write and a register write during the fill to separate the stalled request from the request that passes. All four pin/standby combinations are applied to tell pin priority from plain OR or AND behaviour.

// File: rtl/tsi_hp_pkg.sv
package tsi_hp_pkg;

  // Region selected by the two top address bits.
  typedef enum logic [1:0] {
    RG_NONE = 2'b00,
    RG_REGS = 2'b01,
    RG_CONN = 2'b10,
    RG_DATA = 2'b11
  } region_e;

  localparam int FILL_W = 3;

  // Control register image, bit 0 at the bottom.
  typedef struct packed {
    logic              done;
    logic [FILL_W-1:0] fill_data;
    logic              go;
    logic              fill_mode;
    logic [1:0]        rate;
    logic              sfe;
    logic              standby;
  } ctrl_t;

  localparam int CTRL_OFS = 0;
  localparam int FA_OFS   = 1;
  localparam int FO_BASE  = 2;

endpackage

// File: rtl/tsi_hp_decode.sv
module tsi_hp_decode
  import tsi_hp_pkg::*;
#(
  parameter int HA_W = 12
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [HA_W-1:0] req_addr,
  input  logic            fill_busy,
  output region_e         region,
  output logic [HA_W-3:0] offset,
  output logic            req_ready,
  output logic            cm_we,
  output logic            cm_re,
  output logic            dm_re,
  output logic            rg_we,
  output logic            rg_re,
  output logic            any_re
);

  logic accept;

  assign region = region_e'(req_addr[HA_W-1:HA_W-2]);
  assign offset = req_addr[HA_W-3:0];

  // Only a connection-memory write has to wait for the fill to finish.
  assign req_ready = !(fill_busy && req_write && (region == RG_CONN));
  assign accept    = req_valid && req_ready;

  assign cm_we  = accept &&  req_write && (region == RG_CONN);
  assign cm_re  = accept && !req_write && (region == RG_CONN);
  assign dm_re  = accept && !req_write && (region == RG_DATA);
  assign rg_we  = accept &&  req_write && (region == RG_REGS);
  assign rg_re  = accept && !req_write && (region == RG_REGS);
  assign any_re = accept && !req_write;

endmodule

// File: rtl/tsi_hp_fill.sv
module tsi_hp_fill #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          done_pulse
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) busy <= 1'b0;
      else              addr <= addr + 1'b1;
    end
  end

  // The last entry is written on the same edge that ends the fill.
  assign done_pulse = busy && (addr == LAST);

  assert_fill_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (addr == $past(addr) + 1'b1));

  assert_fill_ends_at_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(addr) == LAST));

endmodule

// File: rtl/tsi_hp_cmem.sv
module tsi_hp_cmem #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_q,
  input  logic [AW-1:0] sw_addr,
  output logic [DW-1:0] sw_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One write port shared by the fill and the host; the fill has priority.
  always_ff @(posedge clk) begin
    if (fill_we)      mem[fill_addr] <= fill_data;
    else if (host_we) mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (host_re) host_q <= mem[host_addr];
  end

  always_ff @(posedge clk) begin
    sw_q <= mem[sw_addr];
  end

  assert_fill_owns_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !host_we);

endmodule

// File: rtl/tsi_hp_regs.sv
module tsi_hp_regs
  import tsi_hp_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int D_W   = 16,
  parameter int N_FO  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rg_we,
  input  logic              rg_re,
  input  logic [OFS_W-1:0]  offset,
  input  logic [D_W-1:0]    wdata,
  input  logic [D_W-1:0]    fa_value,
  input  logic              fill_busy,
  input  logic              fill_done,
  output ctrl_t             ctrl_q,
  output logic              fill_start,
  output logic [N_FO*D_W-1:0] fo_flat,
  output logic [D_W-1:0]    rd_q
);

  localparam int CW = $bits(ctrl_t);
  localparam logic [OFS_W-1:0] OFS_CTRL = OFS_W'(CTRL_OFS);
  localparam logic [OFS_W-1:0] OFS_FA   = OFS_W'(FA_OFS);

  logic           ctrl_wr;
  logic [D_W-1:0] fo_q [N_FO];
  logic [D_W-1:0] rd_val;

  assign ctrl_wr    = rg_we && (offset == OFS_CTRL);
  assign fill_start = ctrl_wr && !fill_busy && wdata[5] && wdata[4];

  // Control register: fields written directly, go guarded, done read-only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.standby   <= wdata[0];
        ctrl_q.sfe       <= wdata[1];
        ctrl_q.rate      <= wdata[3:2];
        ctrl_q.fill_mode <= wdata[4];
        ctrl_q.fill_data <= wdata[6 +: FILL_W];
        if (!fill_busy) ctrl_q.go <= wdata[5] & wdata[4];
      end
      if (fill_done) begin
        ctrl_q.go   <= 1'b0;
        ctrl_q.done <= 1'b1;
      end else if (fill_start) begin
        ctrl_q.done <= 1'b0;
      end
    end
  end

  // Frame offset registers, one per generate slot.
  for (genvar g = 0; g < N_FO; g++) begin : g_fo
    localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(FO_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fo_q[g] <= '0;
      else if (rg_we && (offset == MY_OFS)) fo_q[g] <= wdata;
    end
    assign fo_flat[g*D_W +: D_W] = fo_q[g];
  end

  always_comb begin
    rd_val = '0;
    if (offset == OFS_CTRL)    rd_val = {{(D_W-CW){1'b0}}, ctrl_q};
    else if (offset == OFS_FA) rd_val = fa_value;
    for (int i = 0; i < N_FO; i++) begin
      if (offset == OFS_W'(FO_BASE + i)) rd_val = fo_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rg_re) rd_q <= rd_val;
  end

  assert_go_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.go |-> ctrl_q.fill_mode);

  assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> !ctrl_q.done);

endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
  import tsi_hp_pkg::*;
#(
  parameter int HA_W = 12,
  parameter int D_W  = 16,
  parameter int N_FO = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [HA_W-1:0]      req_addr,
  input  logic [D_W-1:0]       req_wdata,
  output logic                 rsp_valid,
  output logic [D_W-1:0]       rsp_rdata,
  output logic                 dm_re,
  output logic [HA_W-3:0]      dm_addr,
  input  logic [D_W-1:0]       dm_rdata,
  input  logic [HA_W-3:0]      sw_cm_addr,
  output logic [D_W-1:0]       sw_cm_rdata,
  input  logic [D_W-1:0]       fa_value,
  output logic [N_FO*D_W-1:0]  fo_regs,
  output logic                 sfe_out,
  output logic [1:0]           rate_sel,
  input  logic                 ode_pin,
  output logic                 oe_all
);

  localparam int AW = HA_W - 2;

  region_e        region, rsp_src;
  logic [AW-1:0]  offset;
  logic           cm_we, cm_re, rg_we, rg_re, any_re;
  logic           fill_busy, fill_done, fill_start;
  logic [AW-1:0]  fill_addr;
  logic [D_W-1:0] fill_data, cm_q, rg_q;
  ctrl_t          ctrl_q;

  tsi_hp_decode #(.HA_W(HA_W)) u_dec (
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .fill_busy (fill_busy), .region (region), .offset (offset),
    .req_ready (req_ready), .cm_we (cm_we), .cm_re (cm_re), .dm_re (dm_re),
    .rg_we (rg_we), .rg_re (rg_re), .any_re (any_re)
  );

  tsi_hp_regs #(.OFS_W(AW), .D_W(D_W), .N_FO(N_FO)) u_regs (
    .clk (clk), .rst_n (rst_n), .rg_we (rg_we), .rg_re (rg_re),
    .offset (offset), .wdata (req_wdata), .fa_value (fa_value),
    .fill_busy (fill_busy), .fill_done (fill_done), .ctrl_q (ctrl_q),
    .fill_start (fill_start), .fo_flat (fo_regs), .rd_q (rg_q)
  );

  tsi_hp_fill #(.AW(AW)) u_fill (
    .clk (clk), .rst_n (rst_n), .start (fill_start), .busy (fill_busy),
    .addr (fill_addr), .done_pulse (fill_done)
  );

  assign fill_data = {ctrl_q.fill_data, {(D_W-FILL_W){1'b0}}};

  tsi_hp_cmem #(.AW(AW), .DW(D_W)) u_cmem (
    .clk (clk), .rst_n (rst_n), .fill_we (fill_busy), .fill_addr (fill_addr),
    .fill_data (fill_data), .host_we (cm_we), .host_re (cm_re),
    .host_addr (offset), .host_wdata (req_wdata), .host_q (cm_q),
    .sw_addr (sw_cm_addr), .sw_q (sw_cm_rdata)
  );

  // Response stage: remember which source answers the accepted read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_src   <= RG_NONE;
    end else begin
      rsp_valid <= any_re;
      if (any_re) rsp_src <= region;
    end
  end

  always_comb begin
    unique case (rsp_src)
      RG_CONN: rsp_rdata = cm_q;
      RG_DATA: rsp_rdata = dm_rdata;
      RG_REGS: rsp_rdata = rg_q;
      default: rsp_rdata = '0;
    endcase
  end

  assign dm_addr  = offset;
  assign sfe_out  = ctrl_q.sfe;
  assign rate_sel = ctrl_q.rate;
  // The pin overrides the standby bit when high.
  assign oe_all   = ode_pin | ctrl_q.standby;

  assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  assert_dm_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dm_re |-> !req_write);

  assert_fill_end_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_busy) |-> (ctrl_q.done && !ctrl_q.go));

  assert_stall_only_cm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (fill_busy && req_write && req_addr[HA_W-1:HA_W-2] == 2'b10));

  assert_pin_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ode_pin |-> oe_all);

endmodule

// File: tb/tsi_host_port_test.sv
`timescale 1ns/1ps
module tsi_host_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [11:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        dm_re;
  logic [9:0]  dm_addr;
  logic [15:0] dm_rdata;
  logic [9:0]  sw_cm_addr;
  logic [15:0] sw_cm_rdata;
  logic [15:0] fa_value;
  logic [63:0] fo_regs;
  logic        sfe_out;
  logic [1:0]  rate_sel;
  logic        ode_pin, oe_all;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tsi_host_port uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .dm_re (dm_re),
    .dm_addr (dm_addr), .dm_rdata (dm_rdata), .sw_cm_addr (sw_cm_addr),
    .sw_cm_rdata (sw_cm_rdata), .fa_value (fa_value), .fo_regs (fo_regs),
    .sfe_out (sfe_out), .rate_sel (rate_sel), .ode_pin (ode_pin), .oe_all (oe_all)
  );

  // Data memory model: synchronous read, word = {6'b101010, location}.
  always_ff @(posedge clk) begin
    if (dm_re) dm_rdata <= {6'b101010, dm_addr};
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic v;
    check("R2 reset rsp_valid", rsp_valid, 0);
    check("R10 reset ready", req_ready, 1);
    check("R11 reset oe_all", oe_all, 0);
    bus_rd(12'h400, d, v);
    check("R5 reset ctrl", d, 16'h0000);
    check("R2 read valid", v, 1);
    @(negedge clk);
    check("R2 single-cycle valid", rsp_valid, 0);
  endtask

  task automatic t_regs;
    logic [15:0] d; logic v;
    bus_wr(12'h400, 16'h020F);
    check("R2 no response to write", rsp_valid, 0);
    bus_rd(12'h400, d, v);
    check("R5 ctrl readback, done read-only", d, 16'h000F);
    check("R5 sfe_out", sfe_out, 1);
    check("R5 rate_sel", rate_sel, 2'b11);
    for (int k = 0; k < 4; k++) bus_wr(12'h402 + 12'(k), 16'h1000 * 16'(k + 1) + 16'h0ABC);
    for (int k = 0; k < 4; k++) begin
      bus_rd(12'h402 + 12'(k), d, v);
      check("R6 offset reg readback", d, 16'h1000 * 16'(k + 1) + 16'h0ABC);
    end
    check("R6 fo_regs port", fo_regs, 64'h4ABC_3ABC_2ABC_1ABC);
    bus_wr(12'h401, 16'hFFFF);
    bus_rd(12'h401, d, v);
    check("R7 alignment read-only", d, fa_value);
  endtask

  task automatic t_unmapped;
    logic [15:0] d; logic v;
    bus_rd(12'h406, d, v);
    check("R7 unmapped reg offset 6", d, 0);
    bus_rd(12'h7FF, d, v);
    check("R7 unmapped reg offset 1023", d, 0);
    bus_rd(12'h005, d, v);
    check("R1 region 00 reads zero", d, 0);
    check("R2 region 00 still answers", v, 1);
  endtask

  task automatic t_cm;
    logic [15:0] d; logic v;
    bus_wr(12'h807, 16'h1234);
    bus_wr(12'hBFF, 16'hFFFF);
    bus_wr(12'h800, 16'h0F0F);
    bus_rd(12'h807, d, v);
    check("R3 cm[7]", d, 16'h1234);
    bus_rd(12'hBFF, d, v);
    check("R3 cm[1023]", d, 16'hFFFF);
    bus_rd(12'h800, d, v);
    check("R1 cm region distinct from data region", d, 16'h0F0F);
    sw_cm_addr = 10'd7;
    @(negedge clk);
    check("R12 switch port cm[7]", sw_cm_rdata, 16'h1234);
  endtask

  task automatic t_dm;
    logic [15:0] d; logic v;
    bus_rd(12'hD55, d, v);
    check("R4 data memory read", d, 16'hA955);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hC07; req_wdata = 16'hDEAD;
    #1;
    check("R4 no dm_re on write", dm_re, 0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    bus_rd(12'h807, d, v);
    check("R4 dm write leaves cm intact", d, 16'h1234);
    bus_rd(12'hC07, d, v);
    check("R4 dm location unchanged", d, 16'hA807);
  endtask

  task automatic t_oe;
    logic [15:0] d; logic v;
    bus_wr(12'h400, 16'h0000);
    ode_pin = 1'b0; #1;
    check("R11 pin0 standby0", oe_all, 0);
    ode_pin = 1'b1; #1;
    check("R11 pin1 standby0", oe_all, 1);
    @(negedge clk);
    bus_wr(12'h400, 16'h0001);
    ode_pin = 1'b0; #1;
    check("R11 pin0 standby1", oe_all, 1);
    ode_pin = 1'b1; #1;
    check("R11 pin1 standby1", oe_all, 1);
    @(negedge clk);
    ode_pin = 1'b0;
    bus_rd(12'h400, d, v);
    check("R5 standby bit readback", d, 16'h0001);
  endtask

  task automatic t_fill_nomode;
    logic [15:0] d; logic v;
    bus_wr(12'h400, 16'h00E0);
    bus_rd(12'h400, d, v);
    check("R8 go without mode reads 0", d, 16'h00C0);
    repeat (20) @(negedge clk);
    bus_rd(12'h807, d, v);
    check("R8 no fill without mode", d, 16'h1234);
  endtask

  task automatic t_fill;
    logic [15:0] d; logic v;
    bus_wr(12'h400, 16'h0170);
    bus_rd(12'h400, d, v);
    check("R9 go held during fill, done clear", d, 16'h0170);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h402; req_wdata = 16'h5555;
    #1;
    check("R10 reg write ready during fill", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    bus_rd(12'h402, d, v);
    check("R10 reg write during fill landed", d, 16'h5555);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h803; req_wdata = 16'hBEEF;
    #1;
    check("R10 cm write stalled during fill", req_ready, 0);
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    bus_rd(12'h400, d, v);
    check("R9 done set, go cleared", d, 16'h0350);
    bus_rd(12'h800, d, v);
    check("R9 fill entry 0", d, 16'hA000);
    bus_rd(12'h807, d, v);
    check("R9 fill overwrote cm[7]", d, 16'hA000);
    bus_rd(12'hA00, d, v);
    check("R9 fill entry 512", d, 16'hA000);
    bus_rd(12'hBFF, d, v);
    check("R9 fill entry 1023", d, 16'hA000);
    bus_rd(12'h803, d, v);
    check("R10 held write lands after fill", d, 16'hBEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; sw_cm_addr = '0; fa_value = 16'h3C5A; ode_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_cm();
    t_dm();
    t_oe();
    t_fill_nomode();
    t_fill();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule